// File: doc/BRIEF.md
# Fault-Tolerant Cell Concentrator Array

The block is a grid of switch elements with one row per input port and one column per output link. In every cell slot, one clock cycle, each input row that holds a valid cell looks for a free link. It scans the columns from left to right and takes the first one that is still unused. The rows are resolved from the top down, so a row only ever sees the links that the rows above it have left free. Cells that find no link are flagged as lost for that slot. The grid carries one spare column beyond the designed link count. With no fault present, the spare column stays out of service.

A fault report on the configuration port names one element and a kind of stuck fault. For a vertically stuck element, the whole column is forced into pass-through and shows an idle link. The spare column then comes into service, so the number of working links stays at the designed count. For a horizontally stuck element, only the part of the column above the faulty row is forced into pass-through. The faulty row is always granted a link at or left of that column, whether or not it holds a cell, so it never loses a cell. The grid holds one fault at a time, and a new report applies from the next slot onwards.

Top module: `ft_cell_concentrator`

## Requirements
- R1: With no fault stored, the spare column (index L) is always idle. Valid rows are served from top to bottom, and each row takes the lowest-numbered unused column among 0..L-1. A served column shows valid together with that row's payload.
- R2: A row's loss flag is high in a slot exactly when that row had a valid cell and was granted no column. The valid links plus the loss flags always add up to the number of valid input cells.
- R3: With a vertically stuck fault in column j, column j is idle in every slot. The remaining L columns, including the spare, are shared in the same top-down, lowest-free-column order.
- R4: With a horizontally stuck fault at (i, j), rows above i never use column j. Row i always takes the lowest unused column in 0..j and never flags a loss. If row i has no cell, the column it takes shows invalid.
- R5: With a horizontally stuck fault at (i, j), rows below i compete for the columns that are still unused, and these include column j whenever row i took an earlier column.
- R6: Fault kind encoding is 0 = none, 1 = vertically stuck, 2 = horizontally stuck. A report written in a cycle does not change the slot presented in that same cycle. It governs every slot presented afterwards.
- R7: A report is ignored, and the stored fault kept, when its kind is 3, its row is N or more, or its column is L+1 or more.
- R8: Only one fault is stored at a time: a new accepted report replaces the previous one.
- R9: Reset clears all outputs and the stored fault. Link outputs and loss flags appear one clock after the cells they belong to.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; one cell slot per cycle |
| rst_n | input | 1 | Asynchronous active-low reset |
| cell_valid_i | input | N_ROWS | Per-row cell present, bit 0 is the top row |
| cell_data_i | input | N_ROWS*DATA_W | Per-row payload, row r at bits r*DATA_W upward |
| cfg_we | input | 1 | Fault report strobe |
| cfg_kind | input | 2 | Fault kind: 0 none, 1 vertical stuck, 2 horizontal stuck |
| cfg_row | input | ROW_W | Row of the faulty element |
| cfg_col | input | COL_W | Column of the faulty element |
| link_valid_o | output | L_LINKS+SPARE_COLS | Per-column link carries a cell |
| link_data_o | output | (L_LINKS+SPARE_COLS)*DATA_W | Per-column payload, column c at bits c*DATA_W upward |
| loss_o | output | N_ROWS | Per-row cell lost in the slot |

## Verification
The bench sweeps every input pattern of a six-row, three-link grid under no fault, under a vertical fault in each column and under a horizontal fault at every element. A grid that kept the spare column busy in normal service, or let a cell pass through an isolated column, would show a valid idle link. A horizontal fault tests whether the faulty row reserves its link even without a cell. A design that skipped this reservation would give the rows below an extra link, and one that reserved the whole column would starve them. Targeted slots confirm that a report does not touch the slot written alongside it, that malformed reports leave the stored fault alone, and that a new fault fully replaces the old one.

// File: rtl/ftc_pkg.sv
package ftc_pkg;

   // Stored fault kinds; code 3 is never accepted.
   typedef enum logic [1:0] {
      FK_NONE   = 2'd0,
      FK_VSTUCK = 2'd1,
      FK_HSTUCK = 2'd2,
      FK_RSVD   = 2'd3
   } fault_kind_e;

endpackage

// File: rtl/ftc_fault_reg.sv
module ftc_fault_reg
   import ftc_pkg::*;
#(
   parameter int N_ROWS = 64,
   parameter int N_COLS = 13,
   parameter int ROW_W  = 6,
   parameter int COL_W  = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             we_i,
   input  logic [1:0]       kind_i,
   input  logic [ROW_W-1:0] row_i,
   input  logic [COL_W-1:0] col_i,
   output fault_kind_e      kind_o,
   output logic [ROW_W-1:0] row_o,
   output logic [COL_W-1:0] col_o
);

   logic row_ok, col_ok, kind_ok, accept;

   assign row_ok  = int'(row_i) < N_ROWS;
   assign col_ok  = int'(col_i) < N_COLS;
   assign kind_ok = kind_i != 2'd3;
   assign accept  = we_i && row_ok && col_ok && kind_ok;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         kind_o <= FK_NONE;
         row_o  <= '0;
         col_o  <= '0;
      end else if (accept) begin
         kind_o <= fault_kind_e'(kind_i);
         row_o  <= row_i;
         col_o  <= col_i;
      end
   end

   AST_REPORT_REPLACES: assert property (@(posedge clk) disable iff (!rst_n)
      accept |=> (kind_o == $past(kind_i)) && (row_o == $past(row_i))); // R8

   AST_BAD_REPORT_DROPPED: assert property (@(posedge clk) disable iff (!rst_n)
      (we_i && !accept) |=> ($stable(kind_o) && $stable(row_o) && $stable(col_o))); // R7

   AST_STORED_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
      (kind_o != FK_NONE) |-> (int'(row_o) < N_ROWS && int'(col_o) < N_COLS)); // R7

endmodule

// File: rtl/ftc_isolate_map.sv
module ftc_isolate_map
   import ftc_pkg::*;
#(
   parameter int N_ROWS     = 64,
   parameter int N_COLS     = 13,
   parameter int SPARE_COLS = 1,
   parameter int ROW_W      = 6,
   parameter int COL_W      = 4
) (
   input  fault_kind_e                    kind_i,
   input  logic [ROW_W-1:0]               row_i,
   input  logic [COL_W-1:0]               col_i,
   output logic [N_ROWS-1:0][N_COLS-1:0]  force_cross_o,
   output logic [N_ROWS-1:0]              hold_req_o
);

   logic is_v, is_h, is_none;

   assign is_v    = kind_i == FK_VSTUCK;
   assign is_h    = kind_i == FK_HSTUCK;
   assign is_none = kind_i == FK_NONE;

   for (genvar r = 0; r < N_ROWS; r++) begin : g_row
      // The faulty row of a horizontal fault always claims a link.
      assign hold_req_o[r] = is_h && (int'(row_i) == r);

      for (genvar c = 0; c < N_COLS; c++) begin : g_col
         logic hit_col, above_row, park;

         assign hit_col   = int'(col_i) == c;
         assign above_row = r < int'(row_i);

         if (SPARE_COLS != 0 && c == N_COLS - 1) begin : g_spare
            // The spare column only works while a fault is stored.
            assign park = is_none;
         end else begin : g_main
            assign park = 1'b0;
         end

         assign force_cross_o[r][c] = park
                                    | (is_v && hit_col)
                                    | (is_h && hit_col && above_row);
      end
   end

endmodule

// File: rtl/ftc_element.sv
module ftc_element #(
   parameter int DATA_W = 8
) (
   input  logic              force_cross_i,
   input  logic              req_i,
   input  logic              cell_i,
   input  logic [DATA_W-1:0] row_data_i,
   input  logic              busy_i,
   input  logic              lv_i,
   input  logic [DATA_W-1:0] ld_i,
   output logic              req_o,
   output logic              busy_o,
   output logic              lv_o,
   output logic [DATA_W-1:0] ld_o
);

   logic grab;

   // Routing state only when not forced, the row still wants a link and the link is free.
   assign grab   = !force_cross_i && req_i && !busy_i;
   assign req_o  = req_i && !grab;
   assign busy_o = busy_i || grab;
   assign lv_o   = grab ? cell_i : lv_i;
   assign ld_o   = grab ? row_data_i : ld_i;

endmodule

// File: rtl/ftc_grid.sv
module ftc_grid #(
   parameter int N_ROWS = 64,
   parameter int N_COLS = 13,
   parameter int DATA_W = 8
) (
   input  logic [N_ROWS-1:0]             cell_valid_i,
   input  logic [N_ROWS*DATA_W-1:0]      cell_data_i,
   input  logic [N_ROWS-1:0][N_COLS-1:0] force_cross_i,
   input  logic [N_ROWS-1:0]             hold_req_i,
   output logic [N_COLS-1:0]             link_valid_o,
   output logic [N_COLS*DATA_W-1:0]      link_data_o,
   output logic [N_ROWS-1:0]             unserved_o
);

   logic [N_ROWS:0][N_COLS-1:0]             busy_ch;
   logic [N_ROWS:0][N_COLS-1:0]             lv_ch;
   logic [N_ROWS:0][N_COLS-1:0][DATA_W-1:0] ld_ch;
   logic [N_ROWS-1:0][N_COLS:0]             req_ch;

   assign busy_ch[0] = '0;
   assign lv_ch[0]   = '0;
   assign ld_ch[0]   = '0;

   for (genvar r = 0; r < N_ROWS; r++) begin : g_row
      assign req_ch[r][0]  = cell_valid_i[r] | hold_req_i[r];
      assign unserved_o[r] = req_ch[r][N_COLS];

      for (genvar c = 0; c < N_COLS; c++) begin : g_col
         ftc_element #(.DATA_W(DATA_W)) u_elem (
            .force_cross_i (force_cross_i[r][c]),
            .req_i         (req_ch[r][c]),
            .cell_i        (cell_valid_i[r]),
            .row_data_i    (cell_data_i[r*DATA_W +: DATA_W]),
            .busy_i        (busy_ch[r][c]),
            .lv_i          (lv_ch[r][c]),
            .ld_i          (ld_ch[r][c]),
            .req_o         (req_ch[r][c+1]),
            .busy_o        (busy_ch[r+1][c]),
            .lv_o          (lv_ch[r+1][c]),
            .ld_o          (ld_ch[r+1][c])
         );
      end
   end

   for (genvar c = 0; c < N_COLS; c++) begin : g_out
      assign link_valid_o[c]               = lv_ch[N_ROWS][c];
      assign link_data_o[c*DATA_W +: DATA_W] = ld_ch[N_ROWS][c];
   end

   // A link can only show a cell if some row claimed it.
   always_comb begin
      AST_VALID_NEEDS_CLAIM: assert ((lv_ch[N_ROWS] & ~busy_ch[N_ROWS]) == '0); // R1
   end

endmodule

// File: rtl/ft_cell_concentrator.sv
module ft_cell_concentrator
   import ftc_pkg::*;
#(
   parameter int N_ROWS     = 64,
   parameter int L_LINKS    = 12,
   parameter int SPARE_COLS = 1,
   parameter int DATA_W     = 8,
   localparam int N_COLS    = L_LINKS + SPARE_COLS,
   localparam int ROW_W     = (N_ROWS > 1) ? $clog2(N_ROWS) : 1,
   localparam int COL_W     = (N_COLS > 1) ? $clog2(N_COLS) : 1
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic [N_ROWS-1:0]          cell_valid_i,
   input  logic [N_ROWS*DATA_W-1:0]   cell_data_i,
   input  logic                       cfg_we,
   input  logic [1:0]                 cfg_kind,
   input  logic [ROW_W-1:0]           cfg_row,
   input  logic [COL_W-1:0]           cfg_col,
   output logic [N_COLS-1:0]          link_valid_o,
   output logic [N_COLS*DATA_W-1:0]   link_data_o,
   output logic [N_ROWS-1:0]          loss_o
);

   if (N_ROWS < 2) begin : g_bad_rows
      $error("ft_cell_concentrator: N_ROWS must be at least 2");
   end
   if (L_LINKS < 1) begin : g_bad_links
      $error("ft_cell_concentrator: L_LINKS must be at least 1");
   end
   if (SPARE_COLS != 0 && SPARE_COLS != 1) begin : g_bad_spare
      $error("ft_cell_concentrator: SPARE_COLS must be 0 or 1");
   end
   if (DATA_W < 1) begin : g_bad_width
      $error("ft_cell_concentrator: DATA_W must be at least 1");
   end

   fault_kind_e                    f_kind;
   logic [ROW_W-1:0]               f_row;
   logic [COL_W-1:0]               f_col;
   logic [N_ROWS-1:0][N_COLS-1:0]  force_cross;
   logic [N_ROWS-1:0]              hold_req;
   logic [N_COLS-1:0]              g_lv;
   logic [N_COLS*DATA_W-1:0]       g_ld;
   logic [N_ROWS-1:0]              g_unserved;

   ftc_fault_reg #(
      .N_ROWS (N_ROWS),
      .N_COLS (N_COLS),
      .ROW_W  (ROW_W),
      .COL_W  (COL_W)
   ) u_fault (
      .clk    (clk),
      .rst_n  (rst_n),
      .we_i   (cfg_we),
      .kind_i (cfg_kind),
      .row_i  (cfg_row),
      .col_i  (cfg_col),
      .kind_o (f_kind),
      .row_o  (f_row),
      .col_o  (f_col)
   );

   ftc_isolate_map #(
      .N_ROWS     (N_ROWS),
      .N_COLS     (N_COLS),
      .SPARE_COLS (SPARE_COLS),
      .ROW_W      (ROW_W),
      .COL_W      (COL_W)
   ) u_map (
      .kind_i        (f_kind),
      .row_i         (f_row),
      .col_i         (f_col),
      .force_cross_o (force_cross),
      .hold_req_o    (hold_req)
   );

   ftc_grid #(
      .N_ROWS (N_ROWS),
      .N_COLS (N_COLS),
      .DATA_W (DATA_W)
   ) u_grid (
      .cell_valid_i  (cell_valid_i),
      .cell_data_i   (cell_data_i),
      .force_cross_i (force_cross),
      .hold_req_i    (hold_req),
      .link_valid_o  (g_lv),
      .link_data_o   (g_ld),
      .unserved_o    (g_unserved)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         link_valid_o <= '0;
         link_data_o  <= '0;
         loss_o       <= '0;
      end else begin
         link_valid_o <= g_lv;
         link_data_o  <= g_ld;
         loss_o       <= cell_valid_i & g_unserved;
      end
   end

   if (SPARE_COLS != 0) begin : g_spare_chk
      AST_SPARE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
         (f_kind == FK_NONE) |=> !link_valid_o[N_COLS-1]); // R1
   end

   AST_COLUMN_ISOLATED: assert property (@(posedge clk) disable iff (!rst_n)
      (f_kind == FK_VSTUCK) |=> !link_valid_o[$past(f_col)]); // R3

   AST_HELD_ROW_NO_LOSS: assert property (@(posedge clk) disable iff (!rst_n)
      (f_kind == FK_HSTUCK && cell_valid_i[f_row]) |=> !loss_o[$past(f_row)]); // R4

   AST_CELLS_CONSERVED: assert property (@(posedge clk) disable iff (!rst_n)
      rst_n |=> ($countones(link_valid_o) + $countones(loss_o)
                 == $past($countones(cell_valid_i)))); // R2

   AST_LOSS_NEEDS_CELL: assert property (@(posedge clk) disable iff (!rst_n)
      rst_n |=> ((loss_o & ~$past(cell_valid_i)) == '0)); // R2

endmodule

// File: tb/ft_cell_concentrator_test.sv
module ft_cell_concentrator_test;

   localparam int NR = 6;
   localparam int NL = 3;
   localparam int NC = NL + 1;
   localparam int DW = 8;

   logic              clk = 1'b0;
   logic              rst_n;
   logic [NR-1:0]     cell_valid_i;
   logic [NR*DW-1:0]  cell_data_i;
   logic              cfg_we;
   logic [1:0]        cfg_kind;
   logic [2:0]        cfg_row;
   logic [1:0]        cfg_col;
   logic [NC-1:0]     link_valid_o;
   logic [NC*DW-1:0]  link_data_o;
   logic [NR-1:0]     loss_o;

   int checks = 0;
   int fails  = 0;
   int m_kind = 0;
   int m_row  = 0;
   int m_col  = 0;

   logic [NC-1:0]    exp_lv;
   logic [NC*DW-1:0] exp_ld;
   logic [NR-1:0]    exp_loss;

   always #10 clk = ~clk;

   ft_cell_concentrator #(
      .N_ROWS(NR), .L_LINKS(NL), .SPARE_COLS(1), .DATA_W(DW)
   ) uut (
      .clk(clk), .rst_n(rst_n), .cell_valid_i(cell_valid_i), .cell_data_i(cell_data_i),
      .cfg_we(cfg_we), .cfg_kind(cfg_kind), .cfg_row(cfg_row), .cfg_col(cfg_col),
      .link_valid_o(link_valid_o), .link_data_o(link_data_o), .loss_o(loss_o)
   );

   function automatic logic [DW-1:0] payload(int r, int pat);
      return DW'((pat * 13 + r * 41 + 5) & 255);
   endfunction

   task automatic finish_run();
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   endtask

   // Expected outcome from the requirements: top-down rows, lowest usable free column.
   task automatic compute_exp(logic [NR-1:0] pat);
      logic [NC-1:0] taken;
      taken    = '0;
      exp_lv   = '0;
      exp_ld   = '0;
      exp_loss = '0;
      for (int r = 0; r < NR; r++) begin
         bit wants, got;
         wants = pat[r] || (m_kind == 2 && r == m_row);
         got   = 1'b0;
         for (int c = 0; c < NC; c++) begin
            bit usable;
            usable = !(m_kind == 0 && c == NC - 1)
                  && !(m_kind == 1 && c == m_col)
                  && !(m_kind == 2 && c == m_col && r < m_row);
            if (wants && !got && usable && !taken[c]) begin
               taken[c] = 1'b1;
               got      = 1'b1;
               exp_lv[c] = pat[r];
               exp_ld[c*DW +: DW] = payload(r, int'(pat));
            end
         end
         exp_loss[r] = pat[r] && !got;
      end
   endtask

   task automatic drive_cells(logic [NR-1:0] pat);
      cell_valid_i = pat;
      for (int r = 0; r < NR; r++) cell_data_i[r*DW +: DW] = payload(r, int'(pat));
   endtask

   task automatic compare(string tag);
      bit data_ok;
      data_ok = 1'b1;
      for (int c = 0; c < NC; c++)
         if (exp_lv[c] && link_data_o[c*DW +: DW] !== exp_ld[c*DW +: DW]) data_ok = 1'b0;
      checks++;
      if (link_valid_o !== exp_lv || !data_ok) begin
         fails++;
         $display("FAIL %s links: valid %b data %h expected valid %b data %h (kind %0d row %0d col %0d)",
                  tag, link_valid_o, link_data_o, exp_lv, exp_ld, m_kind, m_row, m_col);
      end
      checks++;
      if (loss_o !== exp_loss) begin
         fails++;
         $display("FAIL R2 %s loss: %b expected %b (kind %0d row %0d col %0d)",
                  tag, loss_o, exp_loss, m_kind, m_row, m_col);
      end
   endtask

   // Starts and ends just after a falling edge.
   task automatic run_slot(logic [NR-1:0] pat, string tag);
      drive_cells(pat);
      compute_exp(pat);
      @(negedge clk);
      compare(tag);
   endtask

   task automatic apply_cfg(int k, int r, int c);
      cfg_we   = 1'b1;
      cfg_kind = 2'(k);
      cfg_row  = 3'(r);
      cfg_col  = 2'(c);
      @(negedge clk);
      cfg_we = 1'b0;
      if (k != 3 && r < NR && c < NC) begin
         m_kind = k; m_row = r; m_col = c;
      end
   endtask

   function automatic string kind_tag();
      if (m_kind == 0) return "R1";
      if (m_kind == 1) return "R3";
      return "R4 R5";
   endfunction

   initial begin
      repeat (200000) @(posedge clk);
      checks++;
      fails++;
      $display("FAIL watchdog expired: got running, expected finished");
      finish_run();
   end

   initial begin
      rst_n = 1'b0; cell_valid_i = '0; cell_data_i = '0;
      cfg_we = 1'b0; cfg_kind = '0; cfg_row = '0; cfg_col = '0;
      repeat (3) @(negedge clk);
      checks++;
      if (link_valid_o !== '0 || loss_o !== '0 || link_data_o !== '0) begin
         fails++;
         $display("FAIL R9 reset: valid %b loss %b expected 0 0", link_valid_o, loss_o);
      end
      rst_n = 1'b1;
      @(negedge clk);
      run_slot('1, "R9 R1");

      // Sweep: no fault, each vertical fault, each horizontal fault, all patterns.
      for (int s = 0; s < 1 + NC + NR * NC; s++) begin
         if (s == 0)       apply_cfg(0, 0, 0);
         else if (s <= NC) apply_cfg(1, 0, s - 1);
         else              apply_cfg(2, (s - 1 - NC) / NC, (s - 1 - NC) % NC);
         for (int p = 0; p < (1 << NR); p++) run_slot(NR'(p), kind_tag());
      end

      // R6: report written alongside a slot does not affect that slot.
      apply_cfg(0, 0, 0);
      cfg_we = 1'b1; cfg_kind = 2'd1; cfg_row = 3'd0; cfg_col = 2'd0;
      drive_cells('1);
      compute_exp('1);
      @(negedge clk);
      cfg_we = 1'b0;
      compare("R6 same-slot");
      m_kind = 1; m_row = 0; m_col = 0;
      run_slot('1, "R6 next-slot");

      // R7: malformed reports leave the vertical fault in column 0.
      apply_cfg(3, 1, 1);
      run_slot('1, "R7 kind3");
      apply_cfg(2, 6, 1);
      run_slot(6'b101101, "R7 row6");
      apply_cfg(1, 7, 2);
      run_slot('1, "R7 row7");

      // R8: a horizontal fault replaces a vertical one.
      apply_cfg(1, 0, 1);
      run_slot('1, "R8 vertical");
      apply_cfg(2, 2, 2);
      run_slot('1, "R8 replaced");
      run_slot(6'b111011, "R8 R4 empty held row");

      finish_run();
   end

endmodule